// File: doc/BRIEF.md
# NOR Flash Command State Machine

This block is a synchronous model of a parallel NOR flash that is driven by single-byte commands over a simple memory bus. Software writes command bytes to the array's address range to move the device between modes: array read, identifier read, query, lock setup, status, erase setup and program. In program mode the next bus write is taken as data and is ANDed into the array. An erase confirm fills one whole block with ones. An 8-bit status register records whether the last erase or lock sequence was well formed.

The bus width is a parameter (1, 2 or 4 bytes). Command addresses are normalised by shifting the byte address right by log2 of the bus width, so that command decoding does not depend on the width. A bus write is accepted only when its byte count equals the configured width. Reads return array bytes, an identifier word or the status byte, depending on the current mode. While the device is in query mode a `query_sel` flag tells a neighbouring responder to supply the query table. The read data of this block is then zero.

The bus has no back-pressure. Every write or read strobe is taken in the cycle it is asserted. `rd_valid` rises exactly one cycle after `rd_en`, and `rdata` holds its value until the next read. Strobes must not be asserted together in one cycle.

Top module: `nor_cmd_engine`

## Requirements
- R1: After reset the device is in array-read mode, the status register is 0x80 and every array byte reads 0xFF.
- R2: A write of 0xFF or 0xF0 in any mode except program returns the device to array-read mode.
- R3: In array-read or identifier mode, 0x98 enters query mode only if the normalised address is 0x55. At any other address the mode is unchanged. In query mode `query_sel` is 1 and reads return zero.
- R4: In array-read or identifier mode, 0x90 selects identifier mode, 0x20 erase setup, 0x40 or 0x10 program mode, 0x60 lock setup and 0x70 status mode.
- R5: In array-read or identifier mode, 0x50 sets the status register to 0x80 and leaves the mode unchanged.
- R6: In erase setup, 0xD0 fills the block that holds the address with 0xFF, aligned down to BLK_BYTES, and clears status bits 5 and 4. Any other value sets those two bits instead. Either way the device then enters status mode.
- R7: In program mode the next accepted write is always data, even 0xFF. Each addressed byte becomes old AND new, and the device enters status mode.
- R8: In lock setup, 0x01, 0xD0 and 0x2F are accepted and leave the array and the status unchanged. Any other value sets status bits 5 and 4. The device then enters status mode.
- R9: Reads in status or erase-setup mode return the status byte in bits 7:0, with the upper bits zero. Bit 7 means ready, bit 5 means erase error and bit 4 means program error.
- R10: In identifier mode the normalised address is masked to 9 bits. Offset 0 returns 0x0089, offset 1 returns 0x00AD, offset 5 returns 0x8000, and offset 2 and all other offsets return 0, each word little-endian in `rdata`.
- R11: A write whose `wr_len` differs from the bus width changes neither the mode, the status nor the array.
- R12: An unrecognised command in array-read or identifier mode leaves the mode unchanged and raises `illegal_cmd` for exactly the one cycle after the write. A 0x98 sent to a wrong address is not flagged.
- R13: `rd_valid` is high exactly in the cycle after `rd_en`. In array mode `rdata` holds the bytes at the address aligned down to the bus width, with the lowest address in bits 7:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | AW | Byte address within the array |
| wr_en | input | 1 | Write strobe |
| wr_len | input | 3 | Byte count of this write |
| wdata | input | 8*BB | Write data; the command byte is bits 7:0 |
| rd_en | input | 1 | Read strobe |
| rdata | output | 8*BB | Read data, registered |
| rd_valid | output | 1 | High one cycle after a read strobe |
| query_sel | output | 1 | Device is in query mode |
| illegal_cmd | output | 1 | One-cycle pulse after an unrecognised command |

## Verification
The bound checker watches the mode and status registers on every cycle. It checks that reset commands take effect, that a mis-addressed query command leaves the mode alone, and that program and erase sequences end in status mode with the right error bits. It also checks that writes of the wrong width change nothing, that clearing the status works, and the timing of `rd_valid` and `illegal_cmd`. Only the bench scenarios can show the array contents: AND-only programming, erasing the whole block without touching its neighbours, and the identifier words. The bench also covers the program-mode rule that turns 0xFF into data.

// File: rtl/nor_cmd_pkg.sv
package nor_cmd_pkg;

  typedef enum logic [2:0] {
    M_ARRAY  = 3'd0,
    M_IDENT  = 3'd1,
    M_QUERY  = 3'd2,
    M_LOCK   = 3'd3,
    M_STATUS = 3'd4,
    M_ERASE  = 3'd5,
    M_PROG   = 3'd6
  } mode_t;

  localparam logic [7:0] C_RESET_A = 8'hFF;
  localparam logic [7:0] C_RESET_B = 8'hF0;
  localparam logic [7:0] C_QUERY   = 8'h98;
  localparam logic [7:0] C_IDENT   = 8'h90;
  localparam logic [7:0] C_ERASE   = 8'h20;
  localparam logic [7:0] C_PROG_A  = 8'h40;
  localparam logic [7:0] C_PROG_B  = 8'h10;
  localparam logic [7:0] C_LOCK    = 8'h60;
  localparam logic [7:0] C_CLR     = 8'h50;
  localparam logic [7:0] C_STAT    = 8'h70;
  localparam logic [7:0] C_CONFIRM = 8'hD0;
  localparam logic [7:0] C_LK_ON   = 8'h01;
  localparam logic [7:0] C_LK_DOWN = 8'h2F;

  localparam logic [7:0] ST_INIT   = 8'h80;
  localparam logic [7:0] ST_ERRS   = 8'h30;
  localparam int         QUERY_NA  = 'h55;

  typedef struct packed {
    logic do_prog;
    logic do_erase;
    logic illegal;
  } act_t;

endpackage

// File: rtl/nor_cmd_decode.sv
module nor_cmd_decode
  import nor_cmd_pkg::*;
#(
  parameter int AW = 8
) (
  input  mode_t          mode,
  input  logic [7:0]     status,
  input  logic [7:0]     cmd,
  input  logic [AW-1:0]  naddr,
  output mode_t          mode_nxt,
  output logic [7:0]     status_nxt,
  output act_t           act
);

  always_comb begin
    mode_nxt   = mode;
    status_nxt = status;
    act        = '0;
    if (mode == M_PROG) begin
      act.do_prog = 1'b1;
      mode_nxt    = M_STATUS;
    end else if (cmd == C_RESET_A || cmd == C_RESET_B) begin
      mode_nxt = M_ARRAY;
    end else begin
      case (mode)
        M_ARRAY, M_IDENT: begin
          case (cmd)
            C_QUERY:  if (naddr == AW'(QUERY_NA)) mode_nxt = M_QUERY;
            C_IDENT:  mode_nxt = M_IDENT;
            C_ERASE:  mode_nxt = M_ERASE;
            C_PROG_A,
            C_PROG_B: mode_nxt = M_PROG;
            C_LOCK:   mode_nxt = M_LOCK;
            C_CLR:    status_nxt = ST_INIT;
            C_STAT:   mode_nxt = M_STATUS;
            default:  act.illegal = 1'b1;
          endcase
        end
        M_ERASE: begin
          if (cmd == C_CONFIRM) begin
            act.do_erase = 1'b1;
            status_nxt   = status & ~ST_ERRS;
          end else begin
            status_nxt   = status | ST_ERRS;
          end
          mode_nxt = M_STATUS;
        end
        M_LOCK: begin
          if (!(cmd == C_LK_ON || cmd == C_CONFIRM || cmd == C_LK_DOWN))
            status_nxt = status | ST_ERRS;
          mode_nxt = M_STATUS;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/nor_cell_array.sv
module nor_cell_array #(
  parameter int AW        = 8,
  parameter int BB        = 2,
  parameter int BLK_BYTES = 64,
  localparam int DW       = 8 * BB,
  localparam int DEPTH    = 1 << AW,
  localparam int SH       = $clog2(BB),
  localparam int BLK_SH   = $clog2(BLK_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          prog,
  input  logic          erase,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rd_word
);

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] word_base;
  logic [AW-1:0] blk_base;

  assign word_base = (addr >> SH) << SH;
  assign blk_base  = (addr >> BLK_SH) << BLK_SH;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (erase) begin
      for (int j = 0; j < BLK_BYTES; j++) mem[blk_base + AW'(j)] <= 8'hFF;
    end else if (prog) begin
      for (int k = 0; k < BB; k++)
        mem[word_base + AW'(k)] <= mem[word_base + AW'(k)] & wdata[8*k +: 8];
    end
  end

  always_comb begin
    for (int k = 0; k < BB; k++) rd_word[8*k +: 8] = mem[word_base + AW'(k)];
  end

endmodule

// File: rtl/nor_read_mux.sv
module nor_read_mux
  import nor_cmd_pkg::*;
#(
  parameter int AW  = 8,
  parameter int BB  = 2,
  localparam int DW = 8 * BB
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en,
  input  mode_t         mode,
  input  logic [7:0]    status,
  input  logic [AW-1:0] naddr,
  input  logic [DW-1:0] arr_word,
  output logic [DW-1:0] rdata,
  output logic          rd_valid
);

  logic [8:0]    id_off;
  logic [31:0]   id_word;
  logic [DW-1:0] sel;

  assign id_off = 9'(naddr);

  always_comb begin
    case (id_off)
      9'd0:    id_word = 32'h0000_0089;
      9'd1:    id_word = 32'h0000_00AD;
      9'd5:    id_word = 32'h0000_8000;
      default: id_word = 32'h0;
    endcase
    case (mode)
      M_ARRAY:          sel = arr_word;
      M_IDENT:          sel = DW'(id_word);
      M_STATUS, M_ERASE: sel = DW'(status);
      default:          sel = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata    <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rdata <= sel;
    end
  end

endmodule

// File: rtl/nor_cmd_engine.sv
module nor_cmd_engine
  import nor_cmd_pkg::*;
#(
  parameter int AW        = 8,
  parameter int BB        = 2,
  parameter int BLK_BYTES = 64,
  localparam int DW       = 8 * BB,
  localparam int SH       = $clog2(BB)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          wr_en,
  input  logic [2:0]    wr_len,
  input  logic [DW-1:0] wdata,
  input  logic          rd_en,
  output logic [DW-1:0] rdata,
  output logic          rd_valid,
  output logic          query_sel,
  output logic          illegal_cmd
);

  mode_t         mode_q, mode_nxt;
  logic [7:0]    status_q, status_nxt;
  act_t          act;
  logic          wr_ok;
  logic [AW-1:0] naddr;
  logic [DW-1:0] arr_word;

  assign wr_ok = wr_en && (wr_len == 3'(BB));
  assign naddr = addr >> SH;

  nor_cmd_decode #(.AW(AW)) u_dec (
    .mode       (mode_q),
    .status     (status_q),
    .cmd        (wdata[7:0]),
    .naddr      (naddr),
    .mode_nxt   (mode_nxt),
    .status_nxt (status_nxt),
    .act        (act)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q      <= M_ARRAY;
      status_q    <= ST_INIT;
      illegal_cmd <= 1'b0;
    end else begin
      illegal_cmd <= wr_ok && act.illegal;
      if (wr_ok) begin
        mode_q   <= mode_nxt;
        status_q <= status_nxt;
      end
    end
  end

  nor_cell_array #(.AW(AW), .BB(BB), .BLK_BYTES(BLK_BYTES)) u_arr (
    .clk     (clk),
    .rst_n   (rst_n),
    .prog    (wr_ok && act.do_prog),
    .erase   (wr_ok && act.do_erase),
    .addr    (addr),
    .wdata   (wdata),
    .rd_word (arr_word)
  );

  nor_read_mux #(.AW(AW), .BB(BB)) u_rmux (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_en    (rd_en),
    .mode     (mode_q),
    .status   (status_q),
    .naddr    (naddr),
    .arr_word (arr_word),
    .rdata    (rdata),
    .rd_valid (rd_valid)
  );

  assign query_sel = (mode_q == M_QUERY);

endmodule

// File: rtl/nor_cmd_engine_chk.sv
module nor_cmd_engine_chk
  import nor_cmd_pkg::*;
#(
  parameter int AW  = 8,
  parameter int BB  = 2,
  localparam int DW = 8 * BB,
  localparam int SH = $clog2(BB)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] addr,
  input logic          wr_en,
  input logic [2:0]    wr_len,
  input logic [DW-1:0] wdata,
  input logic          rd_en,
  input logic          rd_valid,
  input logic          illegal_cmd,
  input mode_t         mode,
  input logic [7:0]    status
);

  logic ok;
  logic [7:0] c;
  assign ok = wr_en && (wr_len == 3'(BB));
  assign c  = wdata[7:0];

  p_reset_cmd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ok && mode != M_PROG && (c == 8'hFF || c == 8'hF0)) |=> mode == M_ARRAY);

  p_query_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ok && (mode == M_ARRAY || mode == M_IDENT) && c == 8'h98 &&
     (addr >> SH) != AW'('h55)) |=> mode == $past(mode));

  p_clear_status_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ok && mode == M_ARRAY && c == 8'h50) |=> (status == 8'h80 && mode == M_ARRAY));

  p_erase_ok_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ok && mode == M_ERASE && c == 8'hD0) |=> (status[5:4] == 2'b00 && mode == M_STATUS));

  p_erase_bad_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ok && mode == M_ERASE && c != 8'hD0 && c != 8'hFF && c != 8'hF0)
      |=> (status[5:4] == 2'b11 && mode == M_STATUS));

  p_program_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ok && mode == M_PROG) |=> mode == M_STATUS);

  p_width_ignore_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_len != 3'(BB)) |=> ($stable(mode) && $stable(status)));

  p_illegal_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_cmd |-> ($past(wr_en) && $stable(mode)));

  p_rd_valid_r13: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);

  p_rd_idle_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid);

endmodule

bind nor_cmd_engine nor_cmd_engine_chk #(.AW(AW), .BB(BB)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .addr        (addr),
  .wr_en       (wr_en),
  .wr_len      (wr_len),
  .wdata       (wdata),
  .rd_en       (rd_en),
  .rd_valid    (rd_valid),
  .illegal_cmd (illegal_cmd),
  .mode        (mode_q),
  .status      (status_q)
);

// File: tb/nor_cmd_engine_bench.sv
`timescale 1ns/1ps
module nor_cmd_engine_bench;

  localparam int AW  = 8;
  localparam int BB  = 2;
  localparam int BLK = 64;
  localparam int DW  = 8 * BB;
  localparam int SH  = 1;
  localparam int MA = 0, MI = 1, MQ = 2, ML = 3, MS = 4, ME = 5, MP = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          wr_en = 1'b0;
  logic [2:0]    wr_len = '0;
  logic [DW-1:0] wdata = '0;
  logic          rd_en = 1'b0;
  logic [DW-1:0] rdata;
  logic          rd_valid;
  logic          query_sel;
  logic          illegal_cmd;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  int mmem [1 << AW];
  int mmode;
  int mstat;

  always #2 clk = ~clk;

  nor_cmd_engine #(.AW(AW), .BB(BB), .BLK_BYTES(BLK)) u_nor_cmd_engine (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_len(wr_len),
    .wdata(wdata), .rd_en(rd_en), .rdata(rdata), .rd_valid(rd_valid),
    .query_sel(query_sel), .illegal_cmd(illegal_cmd)
  );

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic int m_read(int a);
    int base, v, off;
    base = a & ~(BB - 1);
    v = 0;
    case (mmode)
      MA: for (int k = 0; k < BB; k++) v |= mmem[base + k] << (8 * k);
      MI: begin
        off = (a >> SH) & 'h1FF;
        v = (off == 0) ? 'h89 : (off == 1) ? 'hAD : (off == 5) ? 'h8000 : 0;
      end
      MS, ME: v = mstat;
      default: v = 0;
    endcase
    return v & ((1 << DW) - 1);
  endfunction

  task automatic m_write(int a, int d, int len, output bit ill);
    int c, base;
    ill = 1'b0;
    c = d & 255;
    if (len != BB) return;
    if (mmode == MP) begin
      base = a & ~(BB - 1);
      for (int k = 0; k < BB; k++) mmem[base + k] &= (d >> (8 * k)) & 255;
      mmode = MS;
      return;
    end
    if (c == 'hFF || c == 'hF0) begin
      mmode = MA;
      return;
    end
    if (mmode == MA || mmode == MI) begin
      case (c)
        'h98: if ((a >> SH) == 'h55) mmode = MQ;
        'h90: mmode = MI;
        'h20: mmode = ME;
        'h40, 'h10: mmode = MP;
        'h60: mmode = ML;
        'h50: mstat = 'h80;
        'h70: mmode = MS;
        default: ill = 1'b1;
      endcase
    end else if (mmode == ME) begin
      if (c == 'hD0) begin
        base = a & ~(BLK - 1);
        for (int j = 0; j < BLK; j++) mmem[base + j] = 255;
        mstat &= ~'h30;
      end else mstat |= 'h30;
      mmode = MS;
    end else if (mmode == ML) begin
      if (!(c == 'h01 || c == 'hD0 || c == 'h2F)) mstat |= 'h30;
      mmode = MS;
    end
  endtask

  // One bus cycle; the model is compared on the following negative edge.
  task automatic op(bit wr, bit rd, int a, int d, int len, string req);
    int exp_rd;
    bit exp_ill;
    wr_en = wr; rd_en = rd; addr = AW'(a); wdata = DW'(d); wr_len = 3'(len);
    exp_rd = m_read(a);
    exp_ill = 1'b0;
    if (wr) m_write(a, d, len, exp_ill);
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    chk(req, "rd_valid", int'(rd_valid), int'(rd));
    if (rd) chk(req, "rdata", int'(rdata), exp_rd);
    chk(req, "illegal_cmd", int'(illegal_cmd), int'(exp_ill));
    chk(req, "query_sel", int'(query_sel), int'(mmode == MQ));
  endtask

  task automatic w(int a, int d, string req);
    op(1'b1, 1'b0, a, d, BB, req);
  endtask

  task automatic r(int a, string req);
    op(1'b0, 1'b1, a, 0, BB, req);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    for (int i = 0; i < (1 << AW); i++) mmem[i] = 255;
    mmode = MA;
    mstat = 'h80;
    repeat (3) @(negedge clk);
    // R1: outputs during reset
    chk("R1", "rdata at reset", int'(rdata), 0);
    chk("R1", "rd_valid at reset", int'(rd_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    op(1'b0, 1'b0, 0, 0, BB, "R1");
    r('h00, "R1");
    r('hFE, "R1");
    w('h00, 'h70, "R4");          // status mode
    r('h00, "R9");                // 0x80 after reset (R1)
    w('h00, 'hFF, "R2");

    // R7 / R13: program clears bits only, lowest address in low byte
    w('h10, 'h40, "R4");
    w('h10, 'h1234, "R7");
    r('h10, "R9");
    w('h00, 'hFF, "R2");
    r('h10, "R13");
    r('h11, "R13");               // unaligned address aligns down
    w('h10, 'h10, "R4");
    w('h10, 'hFF0F, "R7");
    w('h00, 'hF0, "R2");
    r('h10, "R7");
    w('h20, 'h40, "R7");
    w('h20, 'h00FF, "R7");        // 0xFF is data here, not a reset
    r('h20, "R7");
    w('h00, 'hFF, "R2");
    r('h20, "R7");

    // R6: erase block 1 (0x40..0x7F) via an address inside it
    w('h50, 'h40, "R6");
    w('h50, 'h0000, "R6");
    w('h00, 'hFF, "R2");
    w('h7E, 'h40, "R6");
    w('h7E, 'h0101, "R6");
    w('h00, 'hFF, "R2");
    w('h7E, 'h20, "R6");
    r('h7E, "R9");                // erase setup reads status
    w('h7E, 'hD0, "R6");
    r('h00, "R6");
    w('h00, 'hFF, "R2");
    r('h50, "R6");
    r('h7E, "R6");
    r('h10, "R6");                // other block untouched
    w('h00, 'h20, "R6");
    w('h00, 'h33, "R6");          // bad confirm sets error bits
    r('h00, "R9");
    w('h00, 'hFF, "R2");
    r('h10, "R6");
    w('h00, 'h50, "R5");          // clear status, stay in array mode
    r('h10, "R5");
    w('h00, 'h70, "R5");
    r('h00, "R5");
    w('h00, 'hF0, "R2");

    // R3: query entry only at normalised 0x55 (byte 0xAA)
    w('h10, 'h98, "R3");
    r('h10, "R3");
    w('hAA, 'h98, "R3");
    r('h10, "R3");
    w('h00, 'h70, "R3");          // ignored in query mode
    r('h10, "R3");
    w('h00, 'hF0, "R2");
    r('h10, "R2");

    // R10: identifier words
    w('h00, 'h90, "R4");
    r('h00, "R10");
    r('h02, "R10");
    r('h04, "R10");
    r('h0A, "R10");
    r('h06, "R10");
    w('h00, 'h98, "R3");          // wrong address in ID mode
    r('h02, "R3");
    w('h00, 'h20, "R4");          // erase setup from ID mode
    w('h00, 'hFF, "R2");          // reset out of erase setup
    r('h10, "R2");

    // R8: lock setup
    w('h00, 'h60, "R8");
    w('h00, 'h2F, "R8");
    r('h00, "R8");
    w('h00, 'hFF, "R2");
    w('h00, 'h60, "R8");
    w('h00, 'hD0, "R8");
    r('h10, "R8");
    w('h00, 'hFF, "R2");
    r('h10, "R8");                // array untouched by lock commands
    w('h00, 'h60, "R8");
    w('h00, 'h55, "R8");
    r('h00, "R8");
    w('h00, 'hFF, "R2");
    w('h00, 'h50, "R5");

    // R11: width mismatch ignored, also as program data
    op(1'b1, 1'b0, 'h10, 'h40, 1, "R11");
    r('h10, "R11");
    w('h30, 'h40, "R11");
    op(1'b1, 1'b0, 'h30, 'h0000, 4, "R11");
    r('h30, "R11");               // still in program mode: reads zero
    w('h30, 'hAAAA, "R11");
    w('h00, 'hFF, "R2");
    r('h30, "R11");

    // R12: illegal command pulses for one cycle
    w('h00, 'h33, "R12");
    op(1'b0, 1'b0, 0, 0, BB, "R12");
    r('h10, "R12");
    w('h00, 'h90, "R12");
    w('h00, 'hC5, "R12");
    r('h00, "R12");
    w('h00, 'h70, "R12");
    w('h00, 'h33, "R12");         // ignored in status mode, no flag
    r('h00, "R12");
    w('h00, 'hFF, "R2");

    done = 1'b1;
    finish_run();
  end

endmodule